// File: doc/BRIEF.md
# Instruction byte collector and decoder

This block sits behind an instruction fetch stream that delivers one byte per handshake. It treats the first byte it takes as an opcode and works out from its bit pattern whether the instruction is one, two or three bytes long. It then collects the operand bytes that follow and delivers one decoded record: an instruction kind, the raw register, pair and condition fields, the instruction length, an illegal flag, and a 16-bit operand.

Both edges use a valid/ready handshake. The output is a single holding register. While that register is full, the input is stalled, so a new opcode is only taken once the previous record has left. The block does no execution, memory access, program counter or interrupt work.

Top module: `insn_collect`

## Requirements
- R1: While rst_ni is low and after it rises, out_valid_o is 0 and in_ready_o is 1, and any partly collected instruction is dropped, so the next byte taken is decoded as an opcode.
- R2: rec_len_o is 3 for opcodes 00pp0001, 0x22, 0x2A, 0x32, 0x3A, 0xC3, 0xCD, 11ccc010 and 11ccc100. It is 2 for 00ddd110, 11ooo110, 0xD3 and 0xDB. It is 1 for every other opcode. The block takes exactly that many bytes for the record.
- R3: For a 3-byte instruction, rec_opnd_o is {third byte, second byte}, so the low byte arrives first. For a 2-byte instruction it is {8'h00, second byte}. For a 1-byte instruction other than a restart it is 0.
- R4: For a restart opcode 11nnn111 (kind 25), rec_opnd_o equals nnn times 8.
- R5: For every record, rec_dst_o = opcode[5:3], rec_src_o = opcode[2:0], rec_pair_o = opcode[5:4] and rec_cond_o = opcode[5:3].
- R6: Kind codes for opcodes below 0x80: 0x00 gives 0. 00pp0001 gives 3 and 00pp1001 gives 17. 00pp0011 gives 15 and 00pp1011 gives 16. 0x3A gives 4, 0x32 gives 5, 0x2A gives 6 and 0x22 gives 7. 0x0A and 0x1A give 8; 0x02 and 0x12 give 9. 00ddd100 gives 13, 00ddd101 gives 14, 00ddd110 gives 2 and 00xxx111 gives 18. 01dddsss gives 1, except 0x76.
- R7: Kind codes for opcodes from 0x80: 10ooosss gives 11 and 11ooo110 gives 12. 11ccc000 gives 24, 11ccc010 gives 20 and 11ccc100 gives 22. 11pp0001 gives 28, 11pp0101 gives 27 and 11nnn111 gives 25. 0xC3 gives 19, 0xCD gives 21 and 0xC9 gives 23. 0xE9 gives 26, 0xE3 gives 29 and 0xF9 gives 30. 0xDB gives 31 and 0xD3 gives 32. 0xFB gives 33, 0xF3 gives 34 and 0xEB gives 10.
- R8: The twelve unassigned opcodes 0x08, 0x10, 0x18, 0x20, 0x28, 0x30, 0x38, 0xCB, 0xD9, 0xDD, 0xED and 0xFD give rec_bad_o = 1, kind 63 and length 1. No other opcode sets rec_bad_o, and the byte after an unassigned opcode is decoded as an opcode.
- R9: Opcode 0x76 gives kind 35 (halt) and length 1, not kind 1.
- R10: While operand bytes are outstanding and in_valid_i is low, no record appears, and the byte count and partial operand are kept until the remaining bytes arrive.
- R11: While out_valid_o is 1 and out_ready_i is 0, the record stays unchanged and in_ready_o is 0. out_valid_o falls only after a cycle with out_ready_i high.
- R12: out_valid_o rises on the clock edge that accepts the last byte of an instruction. in_ready_o returns to 1 on the edge that delivers the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Fetch byte valid |
| in_byte_i | input | 8 | Fetch byte |
| in_ready_o | output | 1 | Block can take a byte |
| out_valid_o | output | 1 | Record held and valid |
| out_ready_i | input | 1 | Consumer takes the record |
| rec_kind_o | output | 6 | Instruction kind code (R6, R7, R8, R9) |
| rec_bad_o | output | 1 | Unassigned opcode |
| rec_len_o | output | 2 | Instruction length in bytes |
| rec_dst_o | output | 3 | Opcode bits 5:3 as destination |
| rec_src_o | output | 3 | Opcode bits 2:0 as source |
| rec_pair_o | output | 2 | Opcode bits 5:4 as register pair |
| rec_cond_o | output | 3 | Opcode bits 5:3 as condition |
| rec_opnd_o | output | 16 | Assembled operand or restart target |

## Verification
A record is due one cycle after the clock edge that takes the final byte, and in_ready_o is due one cycle after the edge that delivers the record. The bench drives every byte and every consumer acceptance at the falling edge. It then checks out_valid_o, in_ready_o and the record fields at the next falling edge, which is the first point where those registered results are defined. All 256 opcodes are swept. Each is followed by operand bytes derived from the opcode, and the expected kind, length, fields and operand are computed from bit masks in the bench. Separate passes stretch the gaps between operand bytes, hold back the consumer, and pulse reset in the middle of an instruction.

// File: rtl/insn_collect_pkg.sv
package insn_collect_pkg;
  localparam int OP_W   = 8;
  localparam int OPND_W = 2 * OP_W;
  localparam int KIND_W = 6;
  localparam int REG_W  = 3;
  localparam int PAIR_W = 2;
  localparam int LEN_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    K_NOP   = 6'd0,  K_MOVE  = 6'd1,  K_MOVI  = 6'd2,  K_LDPAIR = 6'd3,
    K_LDDIR = 6'd4,  K_STDIR = 6'd5,  K_LDHLM = 6'd6,  K_STHLM  = 6'd7,
    K_LDIND = 6'd8,  K_STIND = 6'd9,  K_XDH   = 6'd10, K_ALUR   = 6'd11,
    K_ALUI  = 6'd12, K_INC   = 6'd13, K_DEC   = 6'd14, K_INCP   = 6'd15,
    K_DECP  = 6'd16, K_ADDP  = 6'd17, K_ACCOP = 6'd18, K_JMP    = 6'd19,
    K_JMPC  = 6'd20, K_CALL  = 6'd21, K_CALLC = 6'd22, K_RET    = 6'd23,
    K_RETC  = 6'd24, K_RST   = 6'd25, K_JMPHL = 6'd26, K_PUSH   = 6'd27,
    K_POP   = 6'd28, K_XSTK  = 6'd29, K_LDSP  = 6'd30, K_PIN    = 6'd31,
    K_POUT  = 6'd32, K_IEN   = 6'd33, K_IDIS  = 6'd34, K_HALT   = 6'd35,
    K_BAD   = 6'd63
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic               bad;
    logic [LEN_W-1:0]   len;
    logic [REG_W-1:0]   dst;
    logic [REG_W-1:0]   src;
    logic [PAIR_W-1:0]  pair;
    logic [REG_W-1:0]   cond;
    logic [OPND_W-1:0]  opnd;
  } rec_t;

  localparam int REC_W = $bits(rec_t);
endpackage

// File: rtl/insn_classify.sv
module insn_classify
  import insn_collect_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  output kind_e            kind_o,
  output logic [LEN_W-1:0] len_o,
  output logic             bad_o
);
  always_comb begin
    kind_o = K_BAD;
    len_o  = 2'd1;
    case (op_i[7:6])
      2'b00: begin
        case (op_i[2:0])
          3'b000: kind_o = (op_i == 8'h00) ? K_NOP : K_BAD;
          3'b001: begin
            kind_o = op_i[3] ? K_ADDP : K_LDPAIR;
            len_o  = op_i[3] ? 2'd1 : 2'd3;
          end
          3'b010: begin
            if (op_i[5]) begin
              len_o = 2'd3;
              case (op_i[4:3])
                2'b00:   kind_o = K_STHLM;
                2'b01:   kind_o = K_LDHLM;
                2'b10:   kind_o = K_STDIR;
                default: kind_o = K_LDDIR;
              endcase
            end else begin
              kind_o = op_i[3] ? K_LDIND : K_STIND;
            end
          end
          3'b011: kind_o = op_i[3] ? K_DECP : K_INCP;
          3'b100: kind_o = K_INC;
          3'b101: kind_o = K_DEC;
          3'b110: begin
            kind_o = K_MOVI;
            len_o  = 2'd2;
          end
          default: kind_o = K_ACCOP;
        endcase
      end
      2'b01: kind_o = (op_i[5:0] == 6'b110110) ? K_HALT : K_MOVE;
      2'b10: kind_o = K_ALUR;
      default: begin
        case (op_i[2:0])
          3'b000: kind_o = K_RETC;
          3'b001: begin
            if (!op_i[3]) kind_o = K_POP;
            else begin
              case (op_i[5:4])
                2'b00:   kind_o = K_RET;
                2'b01:   kind_o = K_BAD;
                2'b10:   kind_o = K_JMPHL;
                default: kind_o = K_LDSP;
              endcase
            end
          end
          3'b010: begin
            kind_o = K_JMPC;
            len_o  = 2'd3;
          end
          3'b011: begin
            case (op_i[5:3])
              3'b000: begin kind_o = K_JMP;  len_o = 2'd3; end
              3'b001: kind_o = K_BAD;
              3'b010: begin kind_o = K_POUT; len_o = 2'd2; end
              3'b011: begin kind_o = K_PIN;  len_o = 2'd2; end
              3'b100: kind_o = K_XSTK;
              3'b101: kind_o = K_XDH;
              3'b110: kind_o = K_IDIS;
              default: kind_o = K_IEN;
            endcase
          end
          3'b100: begin
            kind_o = K_CALLC;
            len_o  = 2'd3;
          end
          3'b101: begin
            if (!op_i[3]) kind_o = K_PUSH;
            else if (op_i[5:4] == 2'b00) begin
              kind_o = K_CALL;
              len_o  = 2'd3;
            end else kind_o = K_BAD;
          end
          3'b110: begin
            kind_o = K_ALUI;
            len_o  = 2'd2;
          end
          default: kind_o = K_RST;
        endcase
      end
    endcase
    bad_o = (kind_o == K_BAD);
  end
endmodule

// File: rtl/insn_hold.sv
module insn_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         take_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/insn_collect.sv
module insn_collect
  import insn_collect_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OP_W-1:0]   in_byte_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [KIND_W-1:0] rec_kind_o,
  output logic              rec_bad_o,
  output logic [LEN_W-1:0]  rec_len_o,
  output logic [REG_W-1:0]  rec_dst_o,
  output logic [REG_W-1:0]  rec_src_o,
  output logic [PAIR_W-1:0] rec_pair_o,
  output logic [REG_W-1:0]  rec_cond_o,
  output logic [OPND_W-1:0] rec_opnd_o
);
  typedef enum logic [1:0] {ST_OP, ST_LO, ST_HI} st_e;

  st_e              st_q;
  logic [OP_W-1:0]  op_q, lo_q;
  logic [OP_W-1:0]  cur_op;
  kind_e            kind;
  logic [LEN_W-1:0] len;
  logic             bad, accept, last, hold_valid;
  rec_t             rec_d, rec_q;

  assign accept = in_valid_i & in_ready_o;
  assign cur_op = (st_q == ST_OP) ? in_byte_i : op_q;

  insn_classify u_cls (
    .op_i   (cur_op),
    .kind_o (kind),
    .len_o  (len),
    .bad_o  (bad)
  );

  assign last = accept & ((st_q == ST_OP && len == 2'd1) ||
                          (st_q == ST_LO && len == 2'd2) ||
                          (st_q == ST_HI));

  always_comb begin
    rec_d.kind = kind;
    rec_d.bad  = bad;
    rec_d.len  = len;
    rec_d.dst  = cur_op[5:3];
    rec_d.src  = cur_op[2:0];
    rec_d.pair = cur_op[5:4];
    rec_d.cond = cur_op[5:3];
    case (len)
      2'd2:    rec_d.opnd = {{(OPND_W-OP_W){1'b0}}, in_byte_i};
      2'd3:    rec_d.opnd = {in_byte_i, lo_q};
      // restart target is the vector number scaled by 8
      default: rec_d.opnd = (kind == K_RST) ?
                            {{(OPND_W-6){1'b0}}, cur_op[5:3], 3'b000} : '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OP;
      op_q <= '0;
      lo_q <= '0;
    end else if (accept) begin
      if (last) st_q <= ST_OP;
      else begin
        case (st_q)
          ST_OP: begin
            op_q <= in_byte_i;
            st_q <= ST_LO;
          end
          default: begin
            lo_q <= in_byte_i;
            st_q <= ST_HI;
          end
        endcase
      end
    end
  end

  insn_hold #(.W(REC_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (last),
    .take_i  (out_ready_i),
    .data_i  (rec_d),
    .valid_o (hold_valid),
    .data_o  (rec_q)
  );

  assign in_ready_o  = ~hold_valid;
  assign out_valid_o = hold_valid;
  assign rec_kind_o  = rec_q.kind;
  assign rec_bad_o   = rec_q.bad;
  assign rec_len_o   = rec_q.len;
  assign rec_dst_o   = rec_q.dst;
  assign rec_src_o   = rec_q.src;
  assign rec_pair_o  = rec_q.pair;
  assign rec_cond_o  = rec_q.cond;
  assign rec_opnd_o  = rec_q.opnd;
endmodule

// File: rtl/insn_collect_chk.sv
module insn_collect_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [5:0]  rec_kind_o,
  input logic        rec_bad_o,
  input logic [1:0]  rec_len_o,
  input logic [2:0]  rec_dst_o,
  input logic [1:0]  rec_pair_o,
  input logic [2:0]  rec_cond_o,
  input logic [15:0] rec_opnd_o
);
  // R11
  rec_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(rec_kind_o) &&
                                    $stable(rec_len_o) && $stable(rec_opnd_o));

  // R11
  drop_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(out_ready_i));

  // R12
  rise_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));

  // R8
  bad_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && rec_bad_o |-> rec_len_o == 2'd1 && rec_kind_o == 6'd63);

  // R2
  len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> rec_len_o != 2'd0);

  // R4
  rst_opnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && rec_kind_o == 6'd25 |->
      rec_opnd_o[2:0] == 3'd0 && rec_opnd_o[15:6] == 10'd0 && rec_len_o == 2'd1);

  // R5
  field_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> rec_cond_o == rec_dst_o && rec_pair_o == rec_dst_o[2:1]);
endmodule

bind insn_collect insn_collect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .rec_kind_o  (rec_kind_o),
  .rec_bad_o   (rec_bad_o),
  .rec_len_o   (rec_len_o),
  .rec_dst_o   (rec_dst_o),
  .rec_pair_o  (rec_pair_o),
  .rec_cond_o  (rec_cond_o),
  .rec_opnd_o  (rec_opnd_o)
);

// File: tb/insn_collect_bench.sv
module insn_collect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, out_valid;
  logic        out_ready = 1'b0;
  logic [5:0]  rec_kind;
  logic        rec_bad;
  logic [1:0]  rec_len;
  logic [2:0]  rec_dst, rec_src, rec_cond;
  logic [1:0]  rec_pair;
  logic [15:0] rec_opnd;

  int n_chk = 0;
  int n_err = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  insn_collect u_insn_collect (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_byte_i(in_byte), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .rec_kind_o(rec_kind), .rec_bad_o(rec_bad), .rec_len_o(rec_len),
    .rec_dst_o(rec_dst), .rec_src_o(rec_src), .rec_pair_o(rec_pair),
    .rec_cond_o(rec_cond), .rec_opnd_o(rec_opnd)
  );

  function automatic int ref_kind(input logic [7:0] o);
    if (o == 8'h00)           return 0;
    if ((o & 8'hCF) == 8'h01) return 3;
    if (o == 8'h22)           return 7;
    if (o == 8'h2A)           return 6;
    if (o == 8'h32)           return 5;
    if (o == 8'h3A)           return 4;
    if ((o & 8'hEF) == 8'h02) return 9;
    if ((o & 8'hEF) == 8'h0A) return 8;
    if ((o & 8'hCF) == 8'h03) return 15;
    if ((o & 8'hCF) == 8'h0B) return 16;
    if ((o & 8'hCF) == 8'h09) return 17;
    if ((o & 8'hC7) == 8'h04) return 13;
    if ((o & 8'hC7) == 8'h05) return 14;
    if ((o & 8'hC7) == 8'h06) return 2;
    if ((o & 8'hC7) == 8'h07) return 18;
    if (o == 8'h76)           return 35;
    if ((o & 8'hC0) == 8'h40) return 1;
    if ((o & 8'hC0) == 8'h80) return 11;
    if ((o & 8'hC7) == 8'hC0) return 24;
    if ((o & 8'hCF) == 8'hC1) return 28;
    if ((o & 8'hCF) == 8'hC5) return 27;
    if ((o & 8'hC7) == 8'hC2) return 20;
    if ((o & 8'hC7) == 8'hC4) return 22;
    if ((o & 8'hC7) == 8'hC6) return 12;
    if ((o & 8'hC7) == 8'hC7) return 25;
    if (o == 8'hC3) return 19;
    if (o == 8'hC9) return 23;
    if (o == 8'hCD) return 21;
    if (o == 8'hD3) return 32;
    if (o == 8'hDB) return 31;
    if (o == 8'hE3) return 29;
    if (o == 8'hE9) return 26;
    if (o == 8'hEB) return 10;
    if (o == 8'hF3) return 34;
    if (o == 8'hF9) return 30;
    if (o == 8'hFB) return 33;
    return 63;
  endfunction

  function automatic int ref_len(input int k);
    if (k inside {3, 4, 5, 6, 7, 19, 20, 21, 22}) return 3;
    if (k inside {2, 12, 31, 32}) return 2;
    return 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_one(input logic [7:0] op, input logic [7:0] lo,
                         input logic [7:0] hi, input int gap);
    int k, l;
    logic [15:0] eo;
    k = ref_kind(op);
    l = ref_len(k);
    send(op);
    if (l > 1) begin
      repeat (gap) begin
        chk("R10 no record while operand pending", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
      end
      chk("R10 ready while collecting", {31'd0, in_ready}, 32'd1);
      send(lo);
      if (l > 2) begin
        repeat (gap) @(negedge clk);
        chk("R10 no record before high byte", {31'd0, out_valid}, 32'd0);
        send(hi);
      end
    end
    chk("R12 record due after last byte", {31'd0, out_valid}, 32'd1);
    if (op[7]) chk("R7 kind", {26'd0, rec_kind}, k);
    else       chk("R6 kind", {26'd0, rec_kind}, k);
    chk("R2 length", {30'd0, rec_len}, l);
    chk("R8 illegal flag", {31'd0, rec_bad}, (k == 63) ? 1 : 0);
    if (rec_bad) n_bad++;
    chk("R5 dst", {29'd0, rec_dst}, (op >> 3) & 8'h07);
    chk("R5 src", {29'd0, rec_src}, op & 8'h07);
    chk("R5 pair", {30'd0, rec_pair}, (op >> 4) & 8'h03);
    chk("R5 cond", {29'd0, rec_cond}, (op >> 3) & 8'h07);
    if (l == 3)      eo = hi * 16'd256 + lo;
    else if (l == 2) eo = {8'h00, lo};
    else if (k == 25) eo = ((op >> 3) & 8'h07) * 16'd8;
    else             eo = 16'h0000;
    if (k == 25) chk("R4 restart target", {16'd0, rec_opnd}, eo);
    else         chk("R3 operand", {16'd0, rec_opnd}, eo);
    if (op == 8'h76) chk("R9 halt kind", {26'd0, rec_kind}, 35);
    take();
    chk("R12 valid drops after delivery", {31'd0, out_valid}, 32'd0);
    chk("R12 ready returns after delivery", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 ready high in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid low after reset", {31'd0, out_valid}, 32'd0);

    // full opcode sweep, operands derived from the opcode
    for (int i = 0; i < 256; i++)
      run_one(i[7:0], i[7:0] ^ 8'h5A, ~i[7:0], 0);
    chk("R8 count of illegal opcodes", n_bad, 12);

    // stretched operand gaps
    run_one(8'hC3, 8'h34, 8'h12, 5);
    run_one(8'h3E, 8'hA5, 8'h00, 4);
    run_one(8'h21, 8'hFF, 8'h80, 3);

    // illegal opcode followed at once by a 2-byte instruction
    send(8'hCB);
    chk("R8 illegal is a 1-byte record", {30'd0, rec_len}, 1);
    take();
    send(8'h06);
    send(8'h77);
    chk("R8 byte after illegal decoded as opcode", {26'd0, rec_kind}, 2);
    chk("R8 operand after illegal", {16'd0, rec_opnd}, 16'h0077);
    take();

    // consumer back-pressure with a pending input byte
    send(8'hFF);
    in_valid = 1'b1;
    in_byte  = 8'h00;
    repeat (4) begin
      @(negedge clk);
      chk("R11 ready low while record held", {31'd0, in_ready}, 32'd0);
      chk("R11 record held", {26'd0, rec_kind}, 25);
      chk("R11 target held", {16'd0, rec_opnd}, 16'h0038);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R11 ready back after take", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 stalled byte taken as fresh opcode", {26'd0, rec_kind}, 0);
    take();

    // reset in the middle of a 3-byte instruction
    send(8'h01);
    send(8'h44);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid low after mid reset", {31'd0, out_valid}, 32'd0);
    chk("R1 ready high after mid reset", {31'd0, in_ready}, 32'd1);
    send(8'h80);
    chk("R1 partial dropped, next byte is opcode", {31'd0, out_valid}, 32'd1);
    chk("R1 kind after mid reset", {26'd0, rec_kind}, 11);
    take();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule